// File: doc/BRIEF.md
# Multibank Row-Register Cached DRAM

This block is a synthesizable behavioural model of a DRAM with a small SRAM cache built into it. The row address space is split into four banks. Each bank has one row-wide register that holds a copy of one array row, and a tag that names the row last read from that bank. A controller drives active-low strobes (row enable, column latch, write enable, refresh, select, output enable), a write/read level, a multiplexed address and a data bus. The model samples all of them on the system clock and decodes each row-enable falling edge into a read hit, read miss, write hit, write miss, internal refresh or illegal attempt.

Reads are always served from a row register. A read miss copies the addressed row from the array into the bank register in one step. Writes go straight to the array through a per-bit mask. The register is only updated when the write's row matches the bank's tag. Cache reads keep working while row enable is high, so a controller can read a page during precharge or refresh. The array is a parameterized row-wide memory. With the default parameters it has 1024 rows, each holding four 8-bit words.

Pins move into an input register on one clock edge. The control state changes on the next edge. Outputs are driven from registers only, so a change on the pins is visible after the second rising edge.

Top module: `cdram_top`

## Requirements
- R1: The bank is selected by row address bits 9:8 (`BANK_LSB`=8). The remaining `ROW_W-2` row bits form that bank's tag. Activity in one bank never changes another bank's register or tag.
- R2: A row-enable fall with `wr_rd`=0, `rfsh_n`=1 and `sel_n`=0 is a read. If the bank's tag matches the row, data comes from the register. If it does not match, the whole row is copied from the array into the register and the tag is reloaded. After reset every tag is invalid, so the first read to each bank is a miss.
- R3: A row-enable fall with `wr_rd`=1, `we_n`=1, `cal_n`=1, `rfsh_n`=1 and `sel_n`=0 starts a write. On a tag match, each posted word goes to both the array and the register. On a mismatch, only the array is written. A write never reloads a tag.
- R4: Inside a write cycle, a word is posted only in clock cycles where `cal_n` and `we_n` are both low. A write start with `we_n` or `cal_n` low is illegal.
- R5: While a write-miss cycle is open, `dout_en` is 0 whatever `oe_n` is. The block of the output ends when row enable rises. During a write hit, reads stay enabled and come from the page being written.
- R6: With `cal_n` high, the column is `addr[1:0]` and it follows the address (static column). A falling edge of `cal_n` latches the column. The latched column holds while `cal_n` stays low, and the live address takes over once `cal_n` rises (page mode).
- R7: `dout_en` is 1 exactly when `sel_n`=0, `oe_n`=0 and no write miss is open. When no write hit is open, `dout` shows the selected column of the register of the bank used by the most recent read cycle, including while `re_n` is high.
- R8: A row-enable fall with `rfsh_n`=0 is a refresh, whatever `sel_n` is. `rfsh_act` is high for the length of the cycle and `rfsh_row` shows the counter. The counter advances by one when row enable rises. Registers and tags do not change.
- R9: A write's bit mask is taken from `din` at the row-enable fall. A 1 enables that bit. The same mask is used for every word written before row enable rises.
- R10: A row-enable fall with `sel_n`=1 and `rfsh_n`=1 is illegal, and so is a bad write start (R4). An illegal fall raises `mode_err` for exactly one cycle and leaves the array, registers, tags and read page unchanged.
- R11: After reset, all registers read 0, the refresh counter is 0, `mode_err` and `rfsh_act` are 0, and the read page is bank 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| re_n | input | 1 | Row enable, active low; its falling edge starts a cycle |
| cal_n | input | 1 | Column latch, active low |
| we_n | input | 1 | Write enable, active low |
| rfsh_n | input | 1 | Refresh request, active low, sampled at row-enable fall |
| sel_n | input | 1 | Device select, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_rd | input | 1 | 1 = write cycle, 0 = read cycle, sampled at row-enable fall |
| addr | input | ROW_W | Row address at row-enable fall, column in bits 1:0 otherwise |
| din | input | DW | Write data; write mask at row-enable fall |
| dout | output | DW | Read data from the selected row register |
| dout_en | output | 1 | Output drive enable |
| rfsh_act | output | 1 | High while a refresh cycle is open |
| rfsh_row | output | ROW_W | Refresh counter, the row refreshed by the next refresh cycle |
| mode_err | output | 1 | One-cycle pulse on an illegal row-enable fall |

## Verification
The assertions check on every cycle the properties that hold at any moment. The output is disabled throughout a write miss, and it is never enabled while the device is deselected. No register changes while a refresh or write-miss cycle is open. An error pulse never comes with a cycle starting. Each refresh cycle advances the counter by exactly one.

The remaining behaviour needs a sequence of cycles, so only the bench scenarios can show it. These scenarios cover:
- a miss against tags that are invalid after reset;
- a write hit that keeps the register coherent;
- a write miss that leaves the page stale until a later read miss fills it;
- bank independence for rows that share tag bits;
- page-mode column holding;
- mask merging across two words;
- illegal starts that are fully ignored.

// File: rtl/cdram_pkg.sv
package cdram_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_BITS = 2;

    // Sampled control pins, all strobes active low except wr_rd.
    typedef struct packed {
        logic re_n;
        logic cal_n;
        logic we_n;
        logic rfsh_n;
        logic sel_n;
        logic oe_n;
        logic wr_rd;
    } strb_t;

    localparam strb_t STRB_REST = '{re_n: 1'b1, cal_n: 1'b1, we_n: 1'b1,
                                    rfsh_n: 1'b1, sel_n: 1'b1, oe_n: 1'b1,
                                    wr_rd: 1'b0};

    // Decoded meaning of one row-enable falling edge.
    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_HIT,
        OP_RD_MISS,
        OP_WR_HIT,
        OP_WR_MISS,
        OP_REF,
        OP_BAD
    } op_e;

    // Kind of row-enable cycle currently open.
    typedef enum logic [2:0] {
        CY_IDLE,
        CY_READ,
        CY_WHIT,
        CY_WMISS,
        CY_REF
    } cyc_e;

endpackage

// File: rtl/cdram_strobes.sv
module cdram_strobes
    import cdram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strb_t         pins_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] din_i,
    output strb_t         cur_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] din_o,
    output logic          re_fall_o,
    output logic          re_rise_o,
    output logic          cal_fall_o
);

    typedef struct packed {
        strb_t         cur;
        logic          re_prev;
        logic          cal_prev;
        logic [AW-1:0] addr;
        logic [DW-1:0] din;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.cur      = pins_i;
        smp_d.re_prev  = smp_q.cur.re_n;
        smp_d.cal_prev = smp_q.cur.cal_n;
        smp_d.addr     = addr_i;
        smp_d.din      = din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q          <= '0;
            smp_q.cur      <= STRB_REST;
            smp_q.re_prev  <= 1'b1;
            smp_q.cal_prev <= 1'b1;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign cur_o      = smp_q.cur;
    assign addr_o     = smp_q.addr;
    assign din_o      = smp_q.din;
    assign re_fall_o  = smp_q.re_prev & ~smp_q.cur.re_n;
    assign re_rise_o  = ~smp_q.re_prev & smp_q.cur.re_n;
    assign cal_fall_o = smp_q.cal_prev & ~smp_q.cur.cal_n;

endmodule

// File: rtl/cdram_tags.sv
module cdram_tags
    import cdram_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int BANK_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] look_row,
    output logic             hit_o,
    input  logic             fill_en,
    input  logic [ROW_W-1:0] fill_row
);

    localparam int TAG_W = ROW_W - BANK_BITS;

    function automatic logic [TAG_W-1:0] strip_bank(input logic [ROW_W-1:0] r);
        logic [TAG_W-1:0] t;
        int j;
        t = '0;
        j = 0;
        for (int i = 0; i < ROW_W; i++) begin
            if (i < BANK_LSB || i >= BANK_LSB + BANK_BITS) begin
                t[j] = r[i];
                j++;
            end
        end
        return t;
    endfunction

    logic [TAG_W-1:0]     tag_d [NUM_BANKS];
    logic [TAG_W-1:0]     tag_q [NUM_BANKS];
    logic [NUM_BANKS-1:0] vld_d, vld_q;

    logic [BANK_BITS-1:0] look_bank, fill_bank;
    assign look_bank = look_row[BANK_LSB +: BANK_BITS];
    assign fill_bank = fill_row[BANK_LSB +: BANK_BITS];

    assign hit_o = vld_q[look_bank] && (tag_q[look_bank] == strip_bank(look_row));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            tag_d[b] = tag_q[b];
            vld_d[b] = vld_q[b];
            if (fill_en && fill_bank == BANK_BITS'(b)) begin
                tag_d[b] = strip_bank(fill_row);
                vld_d[b] = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[b] <= '0;
                vld_q[b] <= 1'b0;
            end else begin
                tag_q[b] <= tag_d[b];
                vld_q[b] <= vld_d[b];
            end
        end

        // R2
        tag_only_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(fill_en && fill_bank == BANK_BITS'(b)) |=> $stable(tag_q[b]) && $stable(vld_q[b]));
    end

endmodule

// File: rtl/cdram_mode_dec.sv
module cdram_mode_dec
    import cdram_pkg::*;
(
    input  logic  re_fall,
    input  strb_t cur,
    input  logic  tag_hit,
    output op_e   op
);

    always_comb begin
        op = OP_NONE;
        if (re_fall) begin
            if (!cur.rfsh_n) begin
                op = OP_REF;
            end else if (cur.sel_n) begin
                op = OP_BAD;
            end else if (!cur.wr_rd) begin
                op = tag_hit ? OP_RD_HIT : OP_RD_MISS;
            end else if (!cur.we_n || !cur.cal_n) begin
                op = OP_BAD;
            end else begin
                op = tag_hit ? OP_WR_HIT : OP_WR_MISS;
            end
        end
    end

endmodule

// File: rtl/cdram_array.sv
module cdram_array #(
    parameter int ROW_W = 10,
    parameter int COL_W = 2,
    parameter int DW    = 8
) (
    input  logic                        clk,
    input  logic [ROW_W-1:0]            rd_row,
    output logic [(1<<COL_W)*DW-1:0]    rd_data,
    input  logic                        wr_en,
    input  logic [ROW_W-1:0]            wr_row,
    input  logic [COL_W-1:0]            wr_col,
    input  logic [DW-1:0]               wr_data,
    input  logic [DW-1:0]               wr_mask
);

    localparam int NROW = 1 << ROW_W;
    localparam int RW   = (1 << COL_W) * DW;

    logic [RW-1:0] mem [NROW];
    logic [DW-1:0] old_word, new_word;

    assign rd_data  = mem[rd_row];
    assign old_word = mem[wr_row][int'(wr_col)*DW +: DW];
    assign new_word = (old_word & ~wr_mask) | (wr_data & wr_mask);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row][int'(wr_col)*DW +: DW] <= new_word;
        end
    end

endmodule

// File: rtl/cdram_top.sv
module cdram_top
    import cdram_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int COL_W    = 2,
    parameter int DW       = 8,
    parameter int BANK_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             re_n,
    input  logic             cal_n,
    input  logic             we_n,
    input  logic             rfsh_n,
    input  logic             sel_n,
    input  logic             oe_n,
    input  logic             wr_rd,
    input  logic [ROW_W-1:0] addr,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_en,
    output logic             rfsh_act,
    output logic [ROW_W-1:0] rfsh_row,
    output logic             mode_err
);

    localparam int RW = (1 << COL_W) * DW;

    typedef struct packed {
        cyc_e                           mode;
        logic [BANK_BITS-1:0]           cyc_bank;
        logic [ROW_W-1:0]               cyc_row;
        logic [DW-1:0]                  mask;
        logic [BANK_BITS-1:0]           rd_bank;
        logic [COL_W-1:0]               col;
        logic [NUM_BANKS-1:0][RW-1:0]   rows;
        logic [ROW_W-1:0]               rcnt;
        logic                           err;
    } st_t;

    st_t st_d, st_q;

    strb_t            cur;
    logic [ROW_W-1:0] s_addr;
    logic [DW-1:0]    s_din;
    logic             re_fall, re_rise, cal_fall;
    logic             tag_hit;
    op_e              op;
    logic [RW-1:0]    arr_row;
    logic [COL_W-1:0] col_now;
    logic             wr_go;
    logic [BANK_BITS-1:0] bank_in, rd_src;

    cdram_strobes #(.AW(ROW_W), .DW(DW)) u_strobes (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     ('{re_n: re_n, cal_n: cal_n, we_n: we_n, rfsh_n: rfsh_n,
                       sel_n: sel_n, oe_n: oe_n, wr_rd: wr_rd}),
        .addr_i     (addr),
        .din_i      (din),
        .cur_o      (cur),
        .addr_o     (s_addr),
        .din_o      (s_din),
        .re_fall_o  (re_fall),
        .re_rise_o  (re_rise),
        .cal_fall_o (cal_fall)
    );

    cdram_tags #(.ROW_W(ROW_W), .BANK_LSB(BANK_LSB)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_row (s_addr),
        .hit_o    (tag_hit),
        .fill_en  (op == OP_RD_MISS),
        .fill_row (s_addr)
    );

    cdram_mode_dec u_dec (
        .re_fall (re_fall),
        .cur     (cur),
        .tag_hit (tag_hit),
        .op      (op)
    );

    cdram_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_array (
        .clk     (clk),
        .rd_row  (s_addr),
        .rd_data (arr_row),
        .wr_en   (wr_go),
        .wr_row  (st_q.cyc_row),
        .wr_col  (col_now),
        .wr_data (s_din),
        .wr_mask (st_q.mask)
    );

    assign bank_in = s_addr[BANK_LSB +: BANK_BITS];
    // Static column follows the pins; page mode holds the column caught at the latch edge.
    assign col_now = (cur.cal_n || cal_fall) ? s_addr[COL_W-1:0] : st_q.col;
    assign wr_go   = (st_q.mode == CY_WHIT || st_q.mode == CY_WMISS)
                     && !cur.re_n && !cur.cal_n && !cur.we_n;

    always_comb begin
        st_d      = st_q;
        st_d.err  = (op == OP_BAD);
        st_d.col  = col_now;

        unique case (op)
            OP_RD_HIT: begin
                st_d.mode    = CY_READ;
                st_d.rd_bank = bank_in;
            end
            OP_RD_MISS: begin
                st_d.mode          = CY_READ;
                st_d.rd_bank       = bank_in;
                st_d.rows[bank_in] = arr_row;
            end
            OP_WR_HIT, OP_WR_MISS: begin
                st_d.mode     = (op == OP_WR_HIT) ? CY_WHIT : CY_WMISS;
                st_d.cyc_bank = bank_in;
                st_d.cyc_row  = s_addr;
                st_d.mask     = s_din;
            end
            OP_REF: begin
                st_d.mode = CY_REF;
            end
            default: ;
        endcase

        if (re_rise) begin
            if (st_q.mode == CY_REF) begin
                st_d.rcnt = st_q.rcnt + 1'b1;
            end
            st_d.mode = CY_IDLE;
        end

        if (wr_go && st_q.mode == CY_WHIT) begin
            st_d.rows[st_q.cyc_bank][int'(col_now)*DW +: DW] =
                (st_q.rows[st_q.cyc_bank][int'(col_now)*DW +: DW] & ~st_q.mask)
                | (s_din & st_q.mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= CY_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_src   = (st_q.mode == CY_WHIT) ? st_q.cyc_bank : st_q.rd_bank;
    assign dout     = st_q.rows[rd_src][int'(col_now)*DW +: DW];
    assign dout_en  = !cur.sel_n && !cur.oe_n && (st_q.mode != CY_WMISS);
    assign rfsh_act = (st_q.mode == CY_REF);
    assign rfsh_row = st_q.rcnt;
    assign mode_err = st_q.err;

    // R5
    wmiss_dout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CY_WMISS) |-> !dout_en);

    // R7
    dout_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!sel_n || !$past(sel_n) || !cur.sel_n));

    // R3
    wmiss_rows_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CY_WMISS) |=> $stable(st_q.rows));

    // R8
    ref_rows_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CY_REF) |=> $stable(st_q.rows) && $stable(st_q.rd_bank));

    // R8
    ref_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_act && re_rise) |=> rfsh_row == ($past(rfsh_row) + 1'b1));

    // R10
    err_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (st_q.mode == CY_IDLE) && $stable(st_q.rows));

    // R10
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> !mode_err);

endmodule

// File: tb/tb_cdram_top.sv
module tb_cdram_top;

    localparam int ROW_W = 10;
    localparam int DW    = 8;

    localparam int K_DOUT = 0;
    localparam int K_EN   = 1;
    localparam int K_ERR  = 2;
    localparam int K_RACT = 3;
    localparam int K_RROW = 4;

    localparam logic [ROW_W-1:0] ROW_A = 10'h005; // bank 0
    localparam logic [ROW_W-1:0] ROW_B = 10'h012; // bank 0
    localparam logic [ROW_W-1:0] ROW_C = 10'h105; // bank 1, same tag bits as A

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             re_n = 1'b1, cal_n = 1'b1, we_n = 1'b1, rfsh_n = 1'b1;
    logic             sel_n = 1'b0, oe_n = 1'b0, wr_rd = 1'b0;
    logic [ROW_W-1:0] addr = '0;
    logic [DW-1:0]    din = '0;
    logic [DW-1:0]    dout;
    logic             dout_en, rfsh_act, mode_err;
    logic [ROW_W-1:0] rfsh_row;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       req;
        string       what;
    } chk_t;

    chk_t sb[$];
    chk_t item;

    always #2 clk = ~clk;

    cdram_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .re_n     (re_n),
        .cal_n    (cal_n),
        .we_n     (we_n),
        .rfsh_n   (rfsh_n),
        .sel_n    (sel_n),
        .oe_n     (oe_n),
        .wr_rd    (wr_rd),
        .addr     (addr),
        .din      (din),
        .dout     (dout),
        .dout_en  (dout_en),
        .rfsh_act (rfsh_act),
        .rfsh_row (rfsh_row),
        .mode_err (mode_err)
    );

    function automatic logic [15:0] observed(input int kind);
        case (kind)
            K_DOUT:  return 16'(dout);
            K_EN:    return 16'(dout_en);
            K_ERR:   return 16'(mode_err);
            K_RACT:  return 16'(rfsh_act);
            default: return 16'(rfsh_row);
        endcase
    endfunction

    // Monitor: compares queued expectations with the outputs away from the rising edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            logic [15:0] act;
            item = sb.pop_front();
            act  = observed(item.kind);
            checks++;
            if (act !== item.exp) begin
                fails++;
                $display("FAIL %s %s: actual %h expected %h", item.req, item.what, act, item.exp);
            end
        end
    end

    task automatic expect_out(input int kind, input logic [15:0] exp,
                              input string req, input string what);
        chk_t c;
        c.kind = kind; c.exp = exp; c.req = req; c.what = what;
        sb.push_back(c);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    task automatic rd_open(input logic [ROW_W-1:0] row);
        @(negedge clk);
        wr_rd = 1'b0; rfsh_n = 1'b1; addr = row; re_n = 1'b0;
        settle();
    endtask

    task automatic re_close();
        @(negedge clk);
        re_n = 1'b1; cal_n = 1'b1; we_n = 1'b1;
        settle();
    endtask

    task automatic set_col(input logic [ROW_W-1:0] c);
        @(negedge clk);
        addr = c;
        settle();
    endtask

    task automatic wr_open(input logic [ROW_W-1:0] row, input logic [DW-1:0] mask);
        @(negedge clk);
        wr_rd = 1'b1; we_n = 1'b1; cal_n = 1'b1; rfsh_n = 1'b1;
        addr = row; din = mask; re_n = 1'b0;
        settle();
    endtask

    task automatic wr_word(input logic [ROW_W-1:0] c, input logic [DW-1:0] d);
        @(negedge clk);
        addr = c; din = d; cal_n = 1'b0; we_n = 1'b0;
        settle();
        @(negedge clk);
        cal_n = 1'b1; we_n = 1'b1;
        settle();
    endtask

    task automatic write_row(input logic [ROW_W-1:0] row, input logic [ROW_W-1:0] c,
                             input logic [DW-1:0] d);
        wr_open(row, 8'hFF);
        wr_word(c, d);
        re_close();
    endtask

    task automatic read_row(input logic [ROW_W-1:0] row);
        rd_open(row);
        re_close();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..R11 scenario hung: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        settle();

        // R11 reset state
        expect_out(K_DOUT, 16'h00, "R11", "register contents after reset");
        expect_out(K_EN,   16'h1,  "R11", "output enable after reset");
        expect_out(K_ERR,  16'h0,  "R11", "error after reset");
        expect_out(K_RACT, 16'h0,  "R11", "refresh active after reset");
        expect_out(K_RROW, 16'h0,  "R11", "refresh counter after reset");

        // R2: tags invalid after reset, so the first read is a miss and fills
        write_row(ROW_A, 10'd1, 8'h11);
        rd_open(ROW_A);
        set_col(10'd1);
        expect_out(K_DOUT, 16'h11, "R2", "first read after reset fills from array");
        re_close();

        // R3: write hit updates the register, seen with re_n high (R7)
        write_row(ROW_A, 10'd1, 8'h22);
        set_col(10'd1);
        expect_out(K_DOUT, 16'h22, "R3", "write hit updates row register");

        // R3: write miss leaves register and tag alone
        write_row(ROW_B, 10'd1, 8'h33);
        set_col(10'd1);
        expect_out(K_DOUT, 16'h22, "R3", "write miss leaves register unchanged");

        // R2: read miss fills the new row
        rd_open(ROW_B);
        set_col(10'd1);
        expect_out(K_DOUT, 16'h33, "R2", "read miss fills written row");
        re_close();

        // R1: banks are independent, even with equal tag bits
        write_row(ROW_C, 10'd1, 8'h44);
        read_row(ROW_C);
        set_col(10'd1);
        expect_out(K_DOUT, 16'h44, "R1", "bank 1 page after fill");
        read_row(ROW_B);
        set_col(10'd1);
        expect_out(K_DOUT, 16'h33, "R1", "bank 0 page kept apart from bank 1");
        read_row(ROW_C);
        set_col(10'd1);
        expect_out(K_DOUT, 16'h44, "R1", "bank 1 page untouched by bank 0 read");
        read_row(ROW_A);
        set_col(10'd1);
        expect_out(K_DOUT, 16'h22, "R2", "read of replaced row misses and refills");

        // R5: write miss disables the output until row enable rises
        wr_open(ROW_B, 8'hFF);
        expect_out(K_EN, 16'h0, "R5", "output off at write-miss start");
        wr_word(10'd1, 8'h66);
        expect_out(K_EN, 16'h0, "R5", "output off after write-miss word");
        re_close();
        expect_out(K_EN,   16'h1,  "R5", "output back on after row enable rises");
        expect_out(K_DOUT, 16'h22, "R7", "read page still the last read row");

        // R5/R3: write hit keeps reads enabled from the page being written
        wr_open(ROW_A, 8'hFF);
        expect_out(K_EN, 16'h1, "R5", "output on during write hit");
        wr_word(10'd2, 8'h77);
        set_col(10'd2);
        expect_out(K_DOUT, 16'h77, "R3", "read during write hit sees new word");
        re_close();

        // R6: static column then page mode
        set_col(10'd1);
        expect_out(K_DOUT, 16'h22, "R6", "static column follows address");
        @(negedge clk);
        addr = 10'd2; cal_n = 1'b0;
        settle();
        expect_out(K_DOUT, 16'h77, "R6", "column latched at latch edge");
        set_col(10'd1);
        expect_out(K_DOUT, 16'h77, "R6", "latched column holds while latch low");
        @(negedge clk);
        cal_n = 1'b1;
        settle();
        expect_out(K_DOUT, 16'h22, "R6", "address takes over after latch rises");

        // R9: one mask applies to every word of the sequence
        write_row(ROW_A, 10'd3, 8'hFF);
        write_row(ROW_A, 10'd0, 8'hAA);
        wr_open(ROW_A, 8'h0F);
        wr_word(10'd0, 8'h55);
        wr_word(10'd3, 8'h55);
        re_close();
        set_col(10'd0);
        expect_out(K_DOUT, 16'hA5, "R9", "masked merge first word");
        set_col(10'd3);
        expect_out(K_DOUT, 16'hF5, "R9", "same mask on second word");
        read_row(ROW_B);
        read_row(ROW_A);
        set_col(10'd0);
        expect_out(K_DOUT, 16'hA5, "R9", "masked merge reached the array");

        // R4: no word posted unless latch and write enable are both low
        wr_open(ROW_A, 8'hFF);
        @(negedge clk);
        addr = 10'd1; din = 8'h99; cal_n = 1'b0;
        settle();
        @(negedge clk);
        cal_n = 1'b1; we_n = 1'b0;
        settle();
        re_close();
        set_col(10'd1);
        expect_out(K_DOUT, 16'h22, "R4", "no write with only one strobe low");

        // R4/R10: write start with write enable low is illegal and ignored
        @(negedge clk);
        wr_rd = 1'b1; we_n = 1'b0; cal_n = 1'b1; addr = ROW_A; din = 8'hFF; re_n = 1'b0;
        repeat (2) @(posedge clk);
        expect_out(K_ERR, 16'h1, "R4", "bad write start flagged");
        @(negedge clk);
        addr = 10'd1; din = 8'h99; cal_n = 1'b0;
        settle();
        re_close();
        set_col(10'd1);
        expect_out(K_DOUT, 16'h22, "R10", "ignored write start posts nothing");

        // R10: row enable while deselected is flagged once and ignored
        @(negedge clk);
        sel_n = 1'b1; wr_rd = 1'b0; rfsh_n = 1'b1; addr = ROW_B; re_n = 1'b0;
        repeat (2) @(posedge clk);
        expect_out(K_ERR, 16'h1, "R10", "deselected row enable flagged");
        @(posedge clk);
        expect_out(K_ERR, 16'h0, "R10", "error lasts one cycle");
        re_close();
        @(negedge clk) sel_n = 1'b0;
        set_col(10'd1);
        expect_out(K_DOUT, 16'h22, "R10", "deselected read did not fill");

        // R8: refresh runs deselected, counter steps on rise, cache untouched
        @(negedge clk);
        sel_n = 1'b1; rfsh_n = 1'b0; re_n = 1'b0;
        repeat (2) @(posedge clk);
        expect_out(K_RACT, 16'h1, "R8", "refresh cycle active");
        expect_out(K_RROW, 16'h0, "R8", "refresh row before step");
        expect_out(K_ERR,  16'h0, "R8", "deselected refresh is legal");
        re_close();
        expect_out(K_RACT, 16'h0, "R8", "refresh ends on rise");
        expect_out(K_RROW, 16'h1, "R8", "counter stepped once");
        @(negedge clk);
        sel_n = 1'b0; rfsh_n = 1'b1;
        settle();
        expect_out(K_DOUT, 16'h22, "R8", "cache page unchanged by refresh");
        @(negedge clk);
        rfsh_n = 1'b0; re_n = 1'b0;
        settle();
        re_close();
        expect_out(K_RROW, 16'h2, "R8", "second refresh steps counter again");
        @(negedge clk) rfsh_n = 1'b1;

        repeat (2) @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule